// File: doc/BRIEF.md
# Two-Channel Disk DMA Register Bank

This block is the software-visible control surface of a two-channel, packet-driven disk DMA engine. It decodes a shared byte-addressed window. Each channel owns a bank of registers, and the bank base is a fixed stride apart for each channel. One global key byte sits above the channel banks. A bank holds a control word, an event status byte, a descriptor count, a next-descriptor pointer, and two FIFO threshold values. The stored values drive the engine core directly, through per-channel output buses.

Writing the control word can fire a one-cycle start pulse into the engine core. The pulse fires only when the global key byte is open. It also does not fire when the same write asserts the logic-reset bit. That bit drives a level soft reset into the core while it is set. While it is set, the channel's status byte is held empty.

The core reports three kinds of event per channel: bus error, stray device interrupt and packet done. Each event sets a sticky status bit. A channel interrupt is raised while any status bit is set, unless the mask bit or the reset bit is set. Reading the status byte returns its contents and empties it.

Top module: `dmachan_regfile`

## Requirements
- R1: After synchronous reset, the control word of each channel reads 0x0100 (interrupt masked, reset bit clear, PIO mode 0). Status, count, pointer and both thresholds read 0. No interrupt, start pulse or soft reset is asserted.
- R2: Channel c's bank starts at 0x80 + 0x20*c. Inside a bank, the registers sit at these offsets: control 0x00 (16 bits), status 0x02 (8 bits), descriptor count 0x04 (16 bits), next-descriptor pointer 0x0C (32 bits), inbound threshold 0x14 (16 bits) and outbound threshold 0x16 (16 bits). Count, pointer and thresholds read back as written and appear on the channel's output buses.
- R3: In the control word, bit 8 is the interrupt mask and bit 5 is the logic reset, which drives `soft_rst`. Bits 1:0 are the PIO mode, and value 3 selects mode 4; they drive `pio_mode`. Bit 7 is the go trigger, and it always reads back as 0.
- R4: A control write with bit 7 set produces no start pulse unless the key byte at 0xC7 holds 7. Writing any other value to 0xC7 closes the key again.
- R5: An accepted go write raises `start_pulse` for that channel only, for exactly one cycle, in the cycle after the write.
- R6: A control write that sets bit 7 and bit 5 together produces no start pulse, even with the key open.
- R7: Core events set status bits: bus error is bit 0, stray interrupt is bit 4 and packet done is bit 6. The bits are sticky. `irq` for a channel is the OR of its status bits, gated off by the mask bit.
- R8: A status read returns the status byte and then empties it, and the interrupt drops with it. An event that arrives in the same cycle as the read is kept. That event does not appear in the value returned by that read.
- R9: While the control reset bit is set, the status byte is held at zero, events are dropped and `irq` stays low. After the bit is cleared, events are recorded again.
- R10: Addresses below 0x80 and unused offsets inside a bank read as zero. Writes to them change nothing. The status byte ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address in the window |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, registered |
| ev_err | input | 2 | Per-channel bus error event |
| ev_stray | input | 2 | Per-channel stray device interrupt event |
| ev_done | input | 2 | Per-channel packet done event |
| start_pulse | output | 2 | Per-channel start strobe to the core |
| soft_rst | output | 2 | Per-channel engine reset level |
| irq | output | 2 | Per-channel interrupt |
| pio_mode | output | 4 | PIO mode field, 2 bits per channel |
| desc_cnt | output | 32 | Descriptor count, 16 bits per channel |
| next_ptr | output | 64 | Next-descriptor pointer, 32 bits per channel |
| fifo_in_thr | output | 32 | Inbound FIFO threshold, 16 bits per channel |
| fifo_out_thr | output | 32 | Outbound FIFO threshold, 16 bits per channel |

## Verification
Each result is due one clock edge after the edge that samples its stimulus. A write updates the stored value and the output buses on that edge, and `start_pulse` rises on it and falls on the next edge. A read updates `bus_rdata` and empties the status byte on the same edge. An event sets its status bit, and therefore `irq`, on the edge that samples it. The bench drives inputs and samples outputs at falling edges. It checks each result at the first falling edge after the due rising edge, and again one cycle later where a value must fall.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [7:0] BANK_BASE   = 8'h80;
    localparam logic [7:0] BANK_STRIDE = 8'h20;
    localparam logic [7:0] KEY_ADDR    = 8'hC7;
    localparam logic [7:0] KEY_OPEN    = 8'h07;

    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_STAT = 5'h02;
    localparam logic [4:0] OFF_CNT  = 5'h04;
    localparam logic [4:0] OFF_PTR  = 5'h0C;
    localparam logic [4:0] OFF_FIN  = 5'h14;
    localparam logic [4:0] OFF_FOUT = 5'h16;

    localparam int B_MASK  = 8;
    localparam int B_GO    = 7;
    localparam int B_RST   = 5;
    localparam int B_ERR   = 0;
    localparam int B_STRAY = 4;
    localparam int B_DONE  = 6;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_STAT, RS_CNT, RS_PTR, RS_FIN, RS_FOUT
    } rsel_e;

    typedef struct packed {
        logic       mask;
        logic       rst;
        logic [1:0] pio;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic stray;
        logic err;
    } stat_t;

    localparam ctrl_t CTRL_INIT = '{mask: 1'b1, rst: 1'b0, pio: 2'd0};

    function automatic rsel_e offset_to_rsel(input logic [4:0] off);
        case (off)
            OFF_CTRL: return RS_CTRL;
            OFF_STAT: return RS_STAT;
            OFF_CNT:  return RS_CNT;
            OFF_PTR:  return RS_PTR;
            OFF_FIN:  return RS_FIN;
            OFF_FOUT: return RS_FOUT;
            default:  return RS_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
        ctrl_t c;
        c.mask = w[B_MASK];
        c.rst  = w[B_RST];
        c.pio  = w[1:0];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_pack(input ctrl_t c);
        logic [15:0] w;
        w = '0;
        w[B_MASK] = c.mask;
        w[B_RST]  = c.rst;
        w[1:0]    = c.pio;
        return w;
    endfunction

    function automatic logic [7:0] stat_pack(input stat_t s);
        logic [7:0] b;
        b = '0;
        b[B_ERR]   = s.err;
        b[B_STRAY] = s.stray;
        b[B_DONE]  = s.done;
        return b;
    endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
    import dcr_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    ch_hit,
    output rsel_e             rsel,
    output logic              key_hit
);
    localparam logic [2:0] BANK_TAG = BANK_BASE[7:5];

    for (genvar g = 0; g < NCH; g++) begin : g_hit
        assign ch_hit[g] = (addr[7:5] == BANK_TAG + 3'(g));
    end

    assign rsel    = offset_to_rsel(addr[4:0]);
    assign key_hit = (addr == KEY_ADDR);
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  rsel_e             rsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              go_open,
    input  logic              ev_err,
    input  logic              ev_stray,
    input  logic              ev_done,
    output logic              start_pulse,
    output logic              soft_rst,
    output logic              irq,
    output logic [1:0]        pio,
    output logic [15:0]       cnt,
    output logic [31:0]       ptr,
    output logic [15:0]       fin,
    output logic [15:0]       fout,
    output logic [DATA_W-1:0] rd_word
);
    ctrl_t       ctrl_q;
    stat_t       stat_q, stat_d;
    logic [15:0] cnt_q, fin_q, fout_q;
    logic [31:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= CTRL_INIT;
            cnt_q       <= '0;
            ptr_q       <= '0;
            fin_q       <= '0;
            fout_q      <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (wr_en) begin
                case (rsel)
                    RS_CTRL: begin
                        ctrl_q      <= ctrl_unpack(wdata[15:0]);
                        start_pulse <= wdata[B_GO] & ~wdata[B_RST] & go_open;
                    end
                    RS_CNT:  cnt_q  <= wdata[15:0];
                    RS_PTR:  ptr_q  <= wdata;
                    RS_FIN:  fin_q  <= wdata[15:0];
                    RS_FOUT: fout_q <= wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // sticky events; a read empties the byte but a same-cycle event survives
    always_comb begin
        stat_d = (rd_en && rsel == RS_STAT) ? '0 : stat_q;
        stat_d.err   = stat_d.err   | ev_err;
        stat_d.stray = stat_d.stray | ev_stray;
        stat_d.done  = stat_d.done  | ev_done;
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.rst) stat_q <= '0;
        else                   stat_q <= stat_d;
    end

    always_comb begin
        case (rsel)
            RS_CTRL: rd_word = {16'd0, ctrl_pack(ctrl_q)};
            RS_STAT: rd_word = {24'd0, stat_pack(stat_q)};
            RS_CNT:  rd_word = {16'd0, cnt_q};
            RS_PTR:  rd_word = ptr_q;
            RS_FIN:  rd_word = {16'd0, fin_q};
            RS_FOUT: rd_word = {16'd0, fout_q};
            default: rd_word = '0;
        endcase
    end

    assign irq      = (|stat_q) & ~ctrl_q.mask & ~ctrl_q.rst;
    assign soft_rst = ctrl_q.rst;
    assign pio      = ctrl_q.pio;
    assign cnt      = cnt_q;
    assign ptr      = ptr_q;
    assign fin      = fin_q;
    assign fout     = fout_q;
endmodule

// File: rtl/dmachan_regfile.sv
module dmachan_regfile
    import dcr_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NCH-1:0]      ev_err,
    input  logic [NCH-1:0]      ev_stray,
    input  logic [NCH-1:0]      ev_done,
    output logic [NCH-1:0]      start_pulse,
    output logic [NCH-1:0]      soft_rst,
    output logic [NCH-1:0]      irq,
    output logic [2*NCH-1:0]    pio_mode,
    output logic [16*NCH-1:0]   desc_cnt,
    output logic [32*NCH-1:0]   next_ptr,
    output logic [16*NCH-1:0]   fifo_in_thr,
    output logic [16*NCH-1:0]   fifo_out_thr
);
    logic [NCH-1:0]    ch_hit;
    rsel_e             rsel;
    logic              key_hit;
    logic [7:0]        key_q;
    logic              go_open;
    logic [DATA_W-1:0] ch_word [NCH];
    logic [DATA_W-1:0] rd_any;

    dcr_decode #(.NCH(NCH)) u_dec (
        .addr    (bus_addr),
        .ch_hit  (ch_hit),
        .rsel    (rsel),
        .key_hit (key_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dcr_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (bus_wr & ch_hit[g]),
            .rd_en       (bus_rd & ch_hit[g]),
            .rsel        (rsel),
            .wdata       (bus_wdata),
            .go_open     (go_open),
            .ev_err      (ev_err[g]),
            .ev_stray    (ev_stray[g]),
            .ev_done     (ev_done[g]),
            .start_pulse (start_pulse[g]),
            .soft_rst    (soft_rst[g]),
            .irq         (irq[g]),
            .pio         (pio_mode[2*g +: 2]),
            .cnt         (desc_cnt[16*g +: 16]),
            .ptr         (next_ptr[32*g +: 32]),
            .fin         (fifo_in_thr[16*g +: 16]),
            .fout        (fifo_out_thr[16*g +: 16]),
            .rd_word     (ch_word[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                    key_q <= '0;
        else if (bus_wr && key_hit) key_q <= bus_wdata[7:0];
    end
    assign go_open = (key_q == KEY_OPEN);

    always_comb begin
        rd_any = key_hit ? {24'd0, key_q} : '0;
        for (int i = 0; i < NCH; i++)
            if (ch_hit[i]) rd_any = rd_any | ch_word[i];
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_any;
    end
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
    import dcr_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCH-1:0]    ev_err,
    input logic [NCH-1:0]    ev_stray,
    input logic [NCH-1:0]    ev_done,
    input logic [NCH-1:0]    start_pulse,
    input logic [NCH-1:0]    soft_rst,
    input logic [NCH-1:0]    irq,
    input logic              go_open
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (start_pulse == '0 && irq == '0 && soft_rst == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        localparam logic [7:0] A_CTRL = BANK_BASE + 8'(g) * BANK_STRIDE + 8'(OFF_CTRL);
        localparam logic [7:0] A_STAT = BANK_BASE + 8'(g) * BANK_STRIDE + 8'(OFF_STAT);

        assert_key_needed_R4: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> $past(go_open));

        assert_go_source_R5: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[B_GO]));

        assert_go_not_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> $past(!bus_wdata[B_RST]));

        assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && bus_addr == A_STAT && !ev_err[g] && !ev_stray[g] && !ev_done[g])
            |=> !irq[g]);

        assert_reset_silent_R9: assert property (@(posedge clk) disable iff (rst)
            soft_rst[g] |-> !irq[g]);
    end
endmodule

bind dmachan_regfile dcr_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ev_err      (ev_err),
    .ev_stray    (ev_stray),
    .ev_done     (ev_done),
    .start_pulse (start_pulse),
    .soft_rst    (soft_rst),
    .irq         (irq),
    .go_open     (go_open)
);

// File: tb/dmachan_regfile_tb.sv
`timescale 1ns/1ps
module dmachan_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ev_err = '0, ev_stray = '0, ev_done = '0;
    logic [1:0]  start_pulse, soft_rst, irq;
    logic [3:0]  pio_mode;
    logic [31:0] desc_cnt, fifo_in_thr, fifo_out_thr;
    logic [63:0] next_ptr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmachan_regfile u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_err(ev_err), .ev_stray(ev_stray), .ev_done(ev_done),
        .start_pulse(start_pulse), .soft_rst(soft_rst), .irq(irq),
        .pio_mode(pio_mode), .desc_cnt(desc_cnt), .next_ptr(next_ptr),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
    );

    task automatic chk(input string req, input [63:0] act, input [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input [7:0] a, input [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input [7:0] a, output [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ev(input int ch, input [2:0] kind); // kind = {done, stray, err}
        @(negedge clk);
        ev_err[ch] = kind[0]; ev_stray[ch] = kind[1]; ev_done[ch] = kind[2];
        @(negedge clk);
        ev_err = '0; ev_stray = '0; ev_done = '0;
    endtask

    task automatic t_reset_R1();
        logic [31:0] d;
        rd(8'h80, d); chk("R1 ctrl0", d, 32'h0100);
        rd(8'hA0, d); chk("R1 ctrl1", d, 32'h0100);
        rd(8'h82, d); chk("R1 stat0", d, 0);
        rd(8'hAC, d); chk("R1 ptr1", d, 0);
        chk("R1 outputs", {start_pulse, soft_rst, irq}, 0);
    endtask

    task automatic t_map_R2();
        logic [31:0] d;
        wr(8'h84, 32'h0000_0001);
        wr(8'hAC, 32'hDEAD_BEE8);
        wr(8'h94, 32'h0000_0100);
        wr(8'hB6, 32'h0000_0200);
        rd(8'h84, d); chk("R2 cnt0", d, 1);
        rd(8'hAC, d); chk("R2 ptr1", d, 32'hDEAD_BEE8);
        rd(8'h94, d); chk("R2 fin0", d, 32'h100);
        rd(8'hB6, d); chk("R2 fout1", d, 32'h200);
        chk("R2 cnt out", desc_cnt, 32'h0000_0001);
        chk("R2 ptr out", next_ptr, 64'hDEAD_BEE8_0000_0000);
        chk("R2 thr out", {fifo_in_thr, fifo_out_thr}, 64'h0000_0100_0200_0000);
    endtask

    task automatic t_ctrl_R3();
        logic [31:0] d;
        wr(8'h80, 32'h0000_0003);
        rd(8'h80, d); chk("R3 ctrl readback", d, 32'h0003);
        chk("R3 pio out", pio_mode, 4'b0011);
        wr(8'h80, 32'h0000_0083);
        rd(8'h80, d); chk("R3 go reads zero", d, 32'h0003);
    endtask

    task automatic t_lock_R4_R5();
        wr(8'h80, 32'h0000_0083);
        chk("R4 locked no pulse", start_pulse, 2'b00);
        wr(8'hC7, 32'h0000_0007);
        wr(8'h80, 32'h0000_0083);
        chk("R5 pulse ch0", start_pulse, 2'b01);
        @(negedge clk);
        chk("R5 pulse one cycle", start_pulse, 2'b00);
        wr(8'hA0, 32'h0000_0180);
        chk("R5 pulse ch1", start_pulse, 2'b10);
        wr(8'hC7, 32'h0000_0005);
        wr(8'h80, 32'h0000_0083);
        chk("R4 relocked no pulse", start_pulse, 2'b00);
        wr(8'hC7, 32'h0000_0007);
    endtask

    task automatic t_rstgo_R6();
        wr(8'h80, 32'h0000_00A3);
        chk("R6 no pulse with reset", start_pulse, 2'b00);
        chk("R6 soft reset on", soft_rst, 2'b01);
        wr(8'h80, 32'h0000_0003);
        chk("R6 soft reset off", soft_rst, 2'b00);
    endtask

    task automatic t_status_R7_R8();
        logic [31:0] d;
        ev(0, 3'b100);
        chk("R7 irq on done", irq, 2'b01);
        rd(8'h82, d); chk("R7 done bit6", d, 32'h40);
        chk("R8 irq drops", irq, 2'b00);
        rd(8'h82, d); chk("R8 emptied", d, 0);
        ev(0, 3'b001);
        chk("R7 irq on err", irq, 2'b01);
        wr(8'h80, 32'h0000_0103);
        chk("R7 mask gates irq", irq, 2'b00);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h82; ev_done[0] = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ev_done = '0;
        chk("R8 read returns old", bus_rdata, 32'h01);
        rd(8'h82, d); chk("R8 same-cycle event kept", d, 32'h40);
        wr(8'h80, 32'h0000_0003);
        ev(1, 3'b011);
        chk("R7 ch1 masked", irq, 2'b00);
        rd(8'hA2, d); chk("R7 err+stray bits", d, 32'h11);
    endtask

    task automatic t_softrst_R9();
        logic [31:0] d;
        wr(8'h80, 32'h0000_0023);
        ev(0, 3'b111);
        chk("R9 irq quiet", irq, 2'b00);
        rd(8'h82, d); chk("R9 event dropped", d, 0);
        wr(8'h80, 32'h0000_0003);
        ev(0, 3'b100);
        chk("R9 resumes", irq, 2'b01);
        rd(8'h82, d); chk("R9 resumed status", d, 32'h40);
    endtask

    task automatic t_unmapped_R10();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R10 low area zero", d, 0);
        wr(8'h88, 32'h0000_FFFF);
        rd(8'h88, d); chk("R10 hole zero", d, 0);
        rd(8'h84, d); chk("R10 cnt untouched", d, 1);
        wr(8'h82, 32'h0000_00FF);
        rd(8'h82, d); chk("R10 stat ignores write", d, 0);
        chk("R10 irq still low", irq, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_map_R2();
        t_ctrl_R3();
        t_lock_R4_R5();
        t_rstgo_R6();
        t_status_R7_R8();
        t_softrst_R9();
        t_unmapped_R10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule